// File: doc/BRIEF.md
# Legacy and Message Interrupt Generator

This block sits at the interrupt edge of a device function. It turns a set of internal request lines into outgoing interrupt events, and it runs in one of three schemes. In the level scheme, one virtual interrupt wire is represented by separate assert and deassert messages on a selectable pin (A to D). In the single-address scheme, each vector becomes a memory write to one shared address, and the data word tells the vectors apart. In the table scheme, each vector owns an address/data pair and a mask bit.

Requests leave through one output slot with a valid/ready handshake. A small write-only register port holds the shared address, the base data word, the mask bits and the per-vector table. When either message scheme is switched on, the level scheme is silenced. If the virtual wire is up at that moment, it is released first with one deassert message.

Top module: `irq_msg_gen`

## Requirements
- R1: After reset `ev_valid` is low, the virtual wire counts as deasserted, and no event is produced while all request lines stay low.
- R2: With both message enables low, an assert message (`ev_kind` 0) on pin `legacy_pin` is issued only when the OR of the request lines goes from 0 to 1. A deassert message (`ev_kind` 1) is issued only when it goes from 1 to 0. Further lines rising or falling while the OR stays constant produce nothing.
- R3: While `msi_en` or `tbl_en` is high, no assert message is issued. If the wire is asserted when a message mode turns on, exactly one deassert message is issued.
- R4: In either message mode, a 0-to-1 edge on request line v marks vector v pending. Each pending vector is issued exactly once as a memory write (`ev_kind` 2).
- R5: In single-address mode (`msi_en` high, `tbl_en` low), the write goes to register 0. Its data is register 1 with the low N bits replaced by the low N bits of the vector number, where N = min(`msi_log2`, log2 NUM_VEC).
- R6: In table mode (`tbl_en` high, which wins over `msi_en`), the write uses the vector's own entry. Register index 4+2v holds its address and 5+2v holds its data.
- R7: In table mode, a vector whose bit is set in register 2 (bit v masks vector v) stays pending without being issued. It is issued after the bit is cleared.
- R8: When several vectors are eligible at once, the lowest-numbered one is issued first.
- R9: While `ev_valid` is high and `ev_ready` low, every output field holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_lvl | input | NUM_VEC | Interrupt request lines, one per vector |
| msi_en | input | 1 | Single-address message mode enable |
| tbl_en | input | 1 | Table message mode enable (dominant) |
| legacy_pin | input | 2 | Virtual wire pin, 0 = A to 3 = D |
| msi_log2 | input | CNT_W | log2 of vectors enabled in single-address mode |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | REG_W | Register index |
| cfg_wdata | input | CFG_W | Register write data |
| ev_ready | input | 1 | Downstream accepts the event |
| ev_valid | output | 1 | Event present |
| ev_kind | output | 2 | 0 assert, 1 deassert, 2 memory write |
| ev_pin | output | 2 | Pin of an assert/deassert message |
| ev_addr | output | ADDR_W | Memory write address |
| ev_data | output | DATA_W | Memory write data |

## Verification
The hardest situation to reach is a mode switch while the virtual wire is up. The bench holds a request line high in level mode until the assert has gone out, then raises the message enable with the line still high. It then expects a single deassert and no repeated assert, and the next fresh edge must come out as a memory write. Masked vectors are also hard to observe, because by design they produce no event. The bench therefore waits a long stretch for silence and then clears the mask to show the pending state was kept.

// File: rtl/irqg_pkg.sv
package irqg_pkg;
   typedef enum logic [1:0] {
      EV_ASSERT   = 2'd0,
      EV_DEASSERT = 2'd1,
      EV_WRITE    = 2'd2
   } ev_kind_e;
endpackage

// File: rtl/irqg_wire_track.sv
module irqg_wire_track (
   input  logic clk,
   input  logic rst_n,
   input  logic src_any,
   input  logic suppress,
   input  logic take,
   output logic need,
   output logic lvl_assert
);
   logic wire_q;
   logic want;

   // the level the receiver should see; message modes force it low
   assign want       = src_any & ~suppress;
   assign need       = want ^ wire_q;
   assign lvl_assert = want;

   always_ff @(posedge clk) begin
      if (!rst_n)    wire_q <= 1'b0;
      else if (take) wire_q <= want;
   end
endmodule

// File: rtl/irqg_vec_table.sv
module irqg_vec_table #(
   parameter int N   = 8,
   parameter int AW  = 32,
   parameter int DW  = 32,
   parameter int CW  = 32,
   parameter int RAW = 5,
   parameter int IW  = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           we,
   input  logic [RAW-1:0] widx,
   input  logic [CW-1:0]  wdata,
   input  logic [IW-1:0]  rd_idx,
   output logic [AW-1:0]  msg_addr,
   output logic [DW-1:0]  base_data,
   output logic [N-1:0]   mask,
   output logic [AW-1:0]  rd_addr,
   output logic [DW-1:0]  rd_data
);
   localparam int TAB_BASE = 4;

   logic [AW-1:0] tab_a [N];
   logic [DW-1:0] tab_d [N];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         msg_addr  <= '0;
         base_data <= '0;
         mask      <= '0;
      end else if (we) begin
         if (widx == RAW'(0)) msg_addr  <= wdata[AW-1:0];
         if (widx == RAW'(1)) base_data <= wdata[DW-1:0];
         if (widx == RAW'(2)) mask      <= wdata[N-1:0];
      end
   end

   for (genvar i = 0; i < N; i++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            tab_a[i] <= '0;
            tab_d[i] <= '0;
         end else if (we) begin
            if (widx == RAW'(TAB_BASE + 2*i))     tab_a[i] <= wdata[AW-1:0];
            if (widx == RAW'(TAB_BASE + 2*i + 1)) tab_d[i] <= wdata[DW-1:0];
         end
      end
   end

   assign rd_addr = tab_a[rd_idx];
   assign rd_data = tab_d[rd_idx];
endmodule

// File: rtl/irqg_pend_arb.sv
module irqg_pend_arb #(
   parameter int N  = 8,
   parameter int IW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          capture,
   input  logic [N-1:0]  rise,
   input  logic [N-1:0]  allow,
   input  logic          take,
   output logic          any,
   output logic [IW-1:0] grant_idx
);
   logic [N-1:0] pend_q;
   logic [N-1:0] elig;
   logic [N-1:0] grant;
   logic [N:0]   seen;

   assign elig    = pend_q & allow;
   assign seen[0] = 1'b0;

   // ripple priority chain, bit 0 wins
   for (genvar i = 0; i < N; i++) begin : g_pri
      assign grant[i]  = elig[i] & ~seen[i];
      assign seen[i+1] = seen[i] | elig[i];
   end
   assign any = seen[N];

   always_comb begin
      grant_idx = '0;
      for (int i = 0; i < N; i++)
         if (grant[i]) grant_idx = IW'(i);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~(take ? grant : '0)) | (capture ? rise : '0);
   end

   // R4
   pend_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (capture && (|rise)) |=> ((pend_q & $past(rise)) == $past(rise)));

   // R7
   blocked_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(pend_q & ~allow)) |=> (((($past(pend_q) & ~$past(allow))) & ~pend_q) == '0));

   // R8
   grant_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
endmodule

// File: rtl/irq_msg_gen.sv
module irq_msg_gen
   import irqg_pkg::*;
#(
   parameter int NUM_VEC = 8,
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   localparam int VEC_W  = $clog2(NUM_VEC),
   localparam int CNT_W  = $clog2(VEC_W + 1),
   localparam int CFG_W  = (ADDR_W > DATA_W) ? ADDR_W : DATA_W,
   localparam int REG_W  = $clog2(4 + 2*NUM_VEC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_VEC-1:0] src_lvl,
   input  logic               msi_en,
   input  logic               tbl_en,
   input  logic [1:0]         legacy_pin,
   input  logic [CNT_W-1:0]   msi_log2,
   input  logic               cfg_we,
   input  logic [REG_W-1:0]   cfg_idx,
   input  logic [CFG_W-1:0]   cfg_wdata,
   input  logic               ev_ready,
   output logic               ev_valid,
   output logic [1:0]         ev_kind,
   output logic [1:0]         ev_pin,
   output logic [ADDR_W-1:0]  ev_addr,
   output logic [DATA_W-1:0]  ev_data
);
   if (NUM_VEC < 2 || (NUM_VEC & (NUM_VEC - 1)) != 0) begin : g_bad_vec
      $error("NUM_VEC must be a power of two and at least 2");
   end
   if (DATA_W < VEC_W) begin : g_bad_data
      $error("DATA_W must hold a vector number");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("ADDR_W too small");
   end

   logic [NUM_VEC-1:0] src_q, rise, allow, mask;
   logic               msg_mode, src_any, lvl_need, lvl_assert;
   logic               vec_any, slot_free, lvl_take, vec_take, hold_q;
   logic [VEC_W-1:0]   gidx;
   logic [ADDR_W-1:0]  msg_addr, tab_addr;
   logic [DATA_W-1:0]  base_data, tab_data, low_mask, msi_data;
   logic [CNT_W-1:0]   n_eff;

   always_ff @(posedge clk) begin
      if (!rst_n) src_q <= '0;
      else        src_q <= src_lvl;
   end

   assign rise      = src_lvl & ~src_q;
   assign src_any   = |src_q;
   assign msg_mode  = msi_en | tbl_en;
   assign allow     = tbl_en ? ~mask : '1;
   assign slot_free = ~ev_valid | ev_ready;
   assign lvl_take  = slot_free & lvl_need;
   assign vec_take  = slot_free & ~lvl_need & vec_any;

   irqg_wire_track u_wire (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_any    (src_any),
      .suppress   (msg_mode),
      .take       (lvl_take),
      .need       (lvl_need),
      .lvl_assert (lvl_assert)
   );

   irqg_pend_arb #(.N(NUM_VEC), .IW(VEC_W)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture   (msg_mode),
      .rise      (rise),
      .allow     (allow),
      .take      (vec_take),
      .any       (vec_any),
      .grant_idx (gidx)
   );

   irqg_vec_table #(
      .N(NUM_VEC), .AW(ADDR_W), .DW(DATA_W), .CW(CFG_W), .RAW(REG_W), .IW(VEC_W)
   ) u_tab (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (cfg_we),
      .widx      (cfg_idx),
      .wdata     (cfg_wdata),
      .rd_idx    (gidx),
      .msg_addr  (msg_addr),
      .base_data (base_data),
      .mask      (mask),
      .rd_addr   (tab_addr),
      .rd_data   (tab_data)
   );

   assign n_eff    = (msi_log2 > CNT_W'(VEC_W)) ? CNT_W'(VEC_W) : msi_log2;
   assign low_mask = ~({DATA_W{1'b1}} << n_eff);
   assign msi_data = (base_data & ~low_mask) | (DATA_W'(gidx) & low_mask);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ev_valid <= 1'b0;
         ev_kind  <= EV_DEASSERT;
         ev_pin   <= '0;
         ev_addr  <= '0;
         ev_data  <= '0;
      end else if (lvl_take) begin
         ev_valid <= 1'b1;
         ev_kind  <= lvl_assert ? EV_ASSERT : EV_DEASSERT;
         ev_pin   <= legacy_pin;
         ev_addr  <= '0;
         ev_data  <= '0;
      end else if (vec_take) begin
         ev_valid <= 1'b1;
         ev_kind  <= EV_WRITE;
         ev_pin   <= '0;
         ev_addr  <= tbl_en ? tab_addr : msg_addr;
         ev_data  <= tbl_en ? tab_data : msi_data;
      end else if (ev_ready) begin
         ev_valid <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) hold_q <= 1'b0;
      else        hold_q <= ev_valid & ~ev_ready;
   end

   // R9
   ev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_kind) && $stable(ev_pin)
                                   && $stable(ev_addr) && $stable(ev_data)));

   // R3
   no_assert_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && !hold_q && ev_kind == EV_ASSERT) |-> $past(!(msi_en || tbl_en)));
endmodule

// File: tb/irq_msg_gen_test.sv
module irq_msg_gen_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  src_lvl = '0;
   logic        msi_en = 1'b0, tbl_en = 1'b0;
   logic [1:0]  legacy_pin = '0;
   logic [1:0]  msi_log2 = '0;
   logic        cfg_we = 1'b0;
   logic [4:0]  cfg_idx = '0;
   logic [31:0] cfg_wdata = '0;
   logic        ev_ready = 1'b1;
   logic        ev_valid;
   logic [1:0]  ev_kind, ev_pin;
   logic [31:0] ev_addr, ev_data;

   int checks = 0, errors = 0, n_ev = 0;
   logic [1:0]  lk [64];
   logic [1:0]  lp [64];
   logic [31:0] la [64];
   logic [31:0] ld [64];

   localparam logic [31:0] MADDR = 32'hFEE0_1000;
   localparam logic [31:0] BASE  = 32'h0000_4A5F;

   always #5 clk = ~clk;

   irq_msg_gen uut (
      .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .msi_en(msi_en), .tbl_en(tbl_en),
      .legacy_pin(legacy_pin), .msi_log2(msi_log2), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_wdata(cfg_wdata), .ev_ready(ev_ready), .ev_valid(ev_valid), .ev_kind(ev_kind),
      .ev_pin(ev_pin), .ev_addr(ev_addr), .ev_data(ev_data)
   );

   always @(negedge clk) begin
      if (rst_n && ev_valid && ev_ready) begin
         if (n_ev < 64) begin
            lk[n_ev] = ev_kind; lp[n_ev] = ev_pin;
            la[n_ev] = ev_addr; ld[n_ev] = ev_data;
         end
         n_ev = n_ev + 1;
      end
   end

   task automatic step();
      @(posedge clk); #2;
   endtask

   task automatic idle(input int n);
      repeat (n) step();
   endtask

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cfg_wr(input int idx, input logic [31:0] d);
      cfg_we = 1'b1; cfg_idx = 5'(idx); cfg_wdata = d;
      step();
      cfg_we = 1'b0;
   endtask

   task automatic pulse(input int v);
      src_lvl[v] = 1'b1; step(); step(); src_lvl[v] = 1'b0;
   endtask

   function automatic logic [31:0] tab_a(input int v);
      return 32'h8000_0004 + 32'(v) * 32'h100;
   endfunction
   function automatic logic [31:0] tab_d(input int v);
      return 32'hC0DE_0000 + 32'(v) * 7;
   endfunction

   initial begin
      #(10 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      check(ev_valid == 1'b0, "R1 valid after reset", ev_valid, 0);
      idle(6);
      check(n_ev == 0, "R1 no event when idle", n_ev, 0);

      cfg_wr(0, MADDR);
      cfg_wr(1, BASE);
      cfg_wr(2, 32'h0);
      for (int v = 0; v < 8; v++) begin
         cfg_wr(4 + 2*v, tab_a(v));
         cfg_wr(5 + 2*v, tab_d(v));
      end

      // R2 level scheme on each pin
      for (int p = 0; p < 4; p++) begin
         legacy_pin = 2'(p);
         n_ev = 0;
         src_lvl = 8'h08; idle(6);
         check(n_ev == 1 && lk[0] == 2'd0 && lp[0] == 2'(p), "R2 assert on rise", {lk[0], lp[0]}, {2'd0, 2'(p)});
         src_lvl = 8'h28; idle(6);
         src_lvl = 8'h20; idle(6);
         check(n_ev == 1, "R2 no message while OR stays high", n_ev, 1);
         src_lvl = 8'h00; idle(6);
         check(n_ev == 2 && lk[1] == 2'd1 && lp[1] == 2'(p), "R2 deassert on fall", {lk[1], lp[1]}, {2'd1, 2'(p)});
      end

      // R3 message mode turned on while wire asserted
      legacy_pin = 2'd2;
      src_lvl = 8'h01; idle(6);
      n_ev = 0;
      msi_en = 1'b1; idle(6);
      check(n_ev == 1 && lk[0] == 2'd1 && lp[0] == 2'd2, "R3 single deassert on enable", {n_ev[7:0], lk[0]}, {8'd1, 2'd1});
      src_lvl = 8'h00; idle(3);
      src_lvl = 8'h01; idle(6);
      check(n_ev == 2 && lk[1] == 2'd2, "R3 R4 write instead of assert", {n_ev[7:0], lk[1]}, {8'd2, 2'd2});
      src_lvl = 8'h00; idle(3);
      check(n_ev == 2, "R3 no message on fall in message mode", n_ev, 2);

      // R5 single-address sweep
      for (int n = 0; n < 4; n++) begin
         msi_log2 = 2'(n);
         for (int v = 0; v < 8; v++) begin
            logic [31:0] m, exp;
            m = (32'h1 << n) - 32'h1;
            exp = (BASE & ~m) | (32'(v) & m);
            n_ev = 0;
            pulse(v); idle(6);
            check(n_ev == 1 && lk[0] == 2'd2 && la[0] == MADDR && ld[0] == exp,
                  "R5 single-address data", {la[0], ld[0]}, {MADDR, exp});
         end
      end

      // R6 table mode, both enables high
      tbl_en = 1'b1;
      for (int v = 0; v < 8; v++) begin
         n_ev = 0;
         pulse(v); idle(6);
         check(n_ev == 1 && la[0] == tab_a(v) && ld[0] == tab_d(v),
               "R6 table entry", {la[0], ld[0]}, {tab_a(v), tab_d(v)});
      end

      // R8 lowest first
      n_ev = 0;
      src_lvl = 8'b0101_0100; step(); step(); src_lvl = 8'h00; idle(10);
      check(n_ev == 3 && ld[0] == tab_d(2) && ld[1] == tab_d(4) && ld[2] == tab_d(6),
            "R8 issue order", {ld[0][7:0], ld[1][7:0], ld[2][7:0]}, {tab_d(2)[7:0], tab_d(4)[7:0], tab_d(6)[7:0]});

      // R7 mask keeps vector pending
      cfg_wr(2, 32'h08);
      n_ev = 0;
      pulse(3); idle(20);
      check(n_ev == 0, "R7 masked vector silent", n_ev, 0);
      pulse(5); idle(6);
      check(n_ev == 1 && ld[0] == tab_d(5), "R7 unmasked neighbour passes", ld[0], tab_d(5));
      cfg_wr(2, 32'h00); idle(6);
      check(n_ev == 2 && ld[1] == tab_d(3), "R7 fires after unmask", ld[1], tab_d(3));

      // R9 hold under backpressure
      ev_ready = 1'b0;
      n_ev = 0;
      pulse(1); idle(3);
      begin
         logic [31:0] a0, d0;
         a0 = ev_addr; d0 = ev_data;
         check(ev_valid == 1'b1 && d0 == tab_d(1), "R9 event presented", d0, tab_d(1));
         idle(5);
         check(ev_valid && ev_addr == a0 && ev_data == d0 && ev_kind == 2'd2,
               "R9 fields held", ev_data, d0);
      end
      ev_ready = 1'b1; idle(4);
      check(n_ev == 1, "R9 one transfer after release", n_ev, 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule